// File: doc/BRIEF.md
# BCH Syndrome Expander over GF(2^13)

This block turns the packed partial remainders that a BCH checker leaves for one sector into the complete list of 2t syndromes S1..S2t. Each syndrome is a 13-bit element of GF(2^13). A caller loads up to 24 sixteen-bit remainders, packed two per 32-bit word, and picks a correction strength. It then pulses `start_i` and waits for `done_o`. The syndromes go on to a locator solver, which is outside this block.

Odd syndromes come from substituting a power of alpha into each remainder. Remainder i produces S(2i+1). Even syndromes are squares of lower ones: S(2j) = S(j)^2. The work is serial. One Horner step runs per clock for the odd values, then one squaring per clock for the even values. The remainders and the strength are captured when `start_i` is accepted, so the inputs may change while the block is working.

Top module: `bchx_syndrome_expand`

## Requirements
- R1: After synchronous reset, `done_o` is low and every field of `synd_o` is zero.
- R2: `cap_sel_i` picks t when start is accepted: 0 selects 2, 1 selects 4, 2 selects 8, 3 selects 12, and 4 to 7 select 24. When `done_o` is high, every syndrome above index 2t reads zero, including values left over from an earlier run with a larger t.
- R3: Remainder i lies in 32-bit word i/2 of `rem_words_i`, where word w occupies bits [32w+31:32w]. An odd i takes bits [31:16] of its word and an even i takes bits [15:0].
- R4: For i below t, S(2i+1) is the XOR of alpha^((2i+1)·j) over every bit j in 0..12 that is set in remainder i. The sum starts from zero. Bits 13..15 of a remainder have no effect. The field is built on x^13+x^4+x^3+x+1, and alpha is the element x (value 0x0002).
- R5: For j = 1..t, S(2j) = S(j)·S(j) in the same field, so a zero S(j) gives a zero S(2j).
- R6: `done_o` is high for exactly one cycle. That cycle follows the 14·t-th rising edge after the edge that accepts `start_i`.
- R7: A `start_i` pulse during a run is ignored. The run finishes with the latency, strength and remainders captured at its own start.
- R8: Between runs, `synd_o` holds its last values even if `rem_words_i` and `cap_sel_i` change.
- Syndrome S(k) appears on `synd_o[13k-1:13(k-1)]` for k = 1..48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation; sampled only while idle |
| cap_sel_i | input | 3 | Correction strength code |
| rem_words_i | input | 384 | Twelve packed 32-bit remainder words |
| synd_o | output | 624 | S1..S48, 13 bits each, S1 at the LSBs |
| done_o | output | 1 | One-cycle pulse when all 2t syndromes are valid |

## Verification
The hardest case to reach from the ports is a start pulse that arrives mid-run. It carries new remainders and a larger strength code, and it must leave no trace in the results. The bench starts a t=2 run and, a few cycles later, applies different words and code 4 with a second start pulse. It then checks both the 28-cycle latency and the syndromes against the first run's data. A second case is stale high syndromes: a t=24 run followed by a t=2 run shows whether the entries above S4 were cleared. A third case is remainders whose only set bits are 13..15, which shows whether those bits leak into the sums.

// File: rtl/bchx_pkg.sv
package bchx_pkg;

    localparam int GF_M    = 13;
    localparam int MAX_T   = 24;
    localparam int REM_W   = 16;
    localparam int WORD_W  = 2 * REM_W;
    localparam int N_WORDS = MAX_T / 2;
    localparam int N_SYN   = 2 * MAX_T;
    localparam int IDX_W   = $clog2(MAX_T + 1);
    localparam int BIT_W   = $clog2(REM_W);
    localparam int SLOT_W  = $clog2(N_SYN);
    localparam int WORD_IW = $clog2(N_WORDS);

    localparam logic [GF_M:0] GF_POLY = 14'h201B;

    typedef logic [GF_M-1:0] gf_t;

    localparam gf_t GF_ONE      = gf_t'(1);
    localparam gf_t GF_ALPHA    = gf_t'(2);
    localparam gf_t GF_ALPHA_SQ = gf_t'(4);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ODD  = 2'd1,
        PH_EVEN = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [BIT_W-1:0]   bit_pos;
        logic [IDX_W-1:0]   t_val;
    } ctrl_t;

    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int n = 0; n < GF_M; n++) begin
            if (b[n]) acc = acc ^ sh;
            if (sh[GF_M-1]) sh = (sh << 1) ^ GF_POLY[GF_M-1:0];
            else            sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic logic [IDX_W-1:0] cap_decode(input logic [2:0] code);
        case (code)
            3'd0:    return IDX_W'(2);
            3'd1:    return IDX_W'(4);
            3'd2:    return IDX_W'(8);
            3'd3:    return IDX_W'(12);
            default: return IDX_W'(24);
        endcase
    endfunction

endpackage

// File: rtl/bchx_ctrl.sv
module bchx_ctrl
    import bchx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  cap_sel_i,
    output ctrl_t       ctrl_o,
    output logic        load_o,
    output logic        done_o
);

    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(GF_M - 1);

    phase_e             phase_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BIT_W-1:0]   bit_q;
    logic [IDX_W-1:0]   t_q;
    logic               done_q;

    assign load_o = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            bit_q   <= '0;
            t_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        t_q     <= cap_decode(cap_sel_i);
                        idx_q   <= '0;
                        bit_q   <= BIT_LAST;
                        phase_q <= PH_ODD;
                    end
                end
                PH_ODD: begin
                    if (bit_q == '0) begin
                        bit_q <= BIT_LAST;
                        if (idx_q == t_q - IDX_ONE) begin
                            idx_q   <= IDX_ONE;
                            phase_q <= PH_EVEN;
                        end else begin
                            idx_q <= idx_q + IDX_ONE;
                        end
                    end else begin
                        bit_q <= bit_q - BIT_W'(1);
                    end
                end
                PH_EVEN: begin
                    if (idx_q == t_q) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign ctrl_o = '{phase: phase_q, idx: idx_q, bit_pos: bit_q, t_val: t_q};
    assign done_o = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);                                             // R6
    AST_DONE_FROM_EVEN: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(phase_q) == PH_EVEN));                         // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && start_i) |=> $stable(t_q));               // R7
    AST_CAP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> (t_q == 2 || t_q == 4 || t_q == 8 ||
                                  t_q == 12 || t_q == 24));              // R2
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ODD) |-> (bit_q < BIT_W'(GF_M)));                 // R4

endmodule

// File: rtl/bchx_horner.sv
module bchx_horner
    import bchx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init_i,
    input  logic  step_i,
    input  logic  last_i,
    input  logic  bit_i,
    output gf_t   acc_nxt_o
);

    gf_t beta_q;
    gf_t acc_q;
    gf_t acc_nxt;

    always_comb begin
        acc_nxt = gf_mul(acc_q, beta_q) ^ {{(GF_M-1){1'b0}}, bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            beta_q <= GF_ALPHA;
            acc_q  <= '0;
        end else if (step_i) begin
            if (last_i) begin
                acc_q  <= '0;
                beta_q <= gf_mul(beta_q, GF_ALPHA_SQ);
            end else begin
                acc_q <= acc_nxt;
            end
        end
    end

    assign acc_nxt_o = acc_nxt;

    AST_BETA_NONZERO: assert property (@(posedge clk) disable iff (rst)
        beta_q != '0);                                                   // R4
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (step_i && last_i && !init_i) |=> (acc_q == '0));                // R4

endmodule

// File: rtl/bchx_square.sv
module bchx_square
    import bchx_pkg::*;
(
    input  gf_t  a_i,
    output gf_t  sq_o
);

    assign sq_o = gf_mul(a_i, a_i);

    always_comb begin
        if (a_i == '0) begin
            AST_SQ_ZERO: assert (sq_o == '0);                            // R5
        end
    end

endmodule

// File: rtl/bchx_syndrome_expand.sv
module bchx_syndrome_expand
    import bchx_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [2:0]                  cap_sel_i,
    input  logic [N_WORDS*WORD_W-1:0]   rem_words_i,
    output logic [N_SYN*GF_M-1:0]       synd_o,
    output logic                        done_o
);

    ctrl_t                ctl;
    logic                 load;
    logic [WORD_W-1:0]    rem_q [N_WORDS];
    gf_t                  syn_q [N_SYN];

    logic [WORD_W-1:0]    cur_word;
    logic [REM_W-1:0]     cur_rem;
    logic                 cur_bit;
    gf_t                  acc_nxt;
    gf_t                  sq_val;
    logic [SLOT_W-1:0]    odd_slot;
    logic [SLOT_W-1:0]    even_slot;
    logic [SLOT_W-1:0]    src_slot;
    logic                 odd_step;
    logic                 odd_last;

    bchx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cap_sel_i (cap_sel_i),
        .ctrl_o    (ctl),
        .load_o    (load),
        .done_o    (done_o)
    );

    // remainder i: word i/2, upper half for odd i
    assign cur_word = rem_q[ctl.idx[WORD_IW:1]];
    assign cur_rem  = ctl.idx[0] ? cur_word[WORD_W-1:REM_W] : cur_word[REM_W-1:0];
    assign cur_bit  = cur_rem[ctl.bit_pos];

    assign odd_step = (ctl.phase == PH_ODD);
    assign odd_last = (ctl.bit_pos == '0);

    bchx_horner u_horner (
        .clk       (clk),
        .rst       (rst),
        .init_i    (load),
        .step_i    (odd_step),
        .last_i    (odd_last),
        .bit_i     (cur_bit),
        .acc_nxt_o (acc_nxt)
    );

    // zero-based slots: S(2i+1) -> 2i, S(2k) -> 2k-1, S(k) -> k-1
    assign odd_slot  = {ctl.idx, 1'b0};
    assign even_slot = {ctl.idx, 1'b0} - SLOT_W'(1);
    assign src_slot  = {1'b0, ctl.idx} - SLOT_W'(1);

    bchx_square u_square (
        .a_i  (syn_q[src_slot]),
        .sq_o (sq_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < N_WORDS; w++) rem_q[w] <= '0;
        end else if (load) begin
            for (int w = 0; w < N_WORDS; w++)
                rem_q[w] <= rem_words_i[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            for (int k = 0; k < N_SYN; k++) syn_q[k] <= '0;
        end else if (odd_step && odd_last) begin
            syn_q[odd_slot] <= acc_nxt;
        end else if (ctl.phase == PH_EVEN) begin
            syn_q[even_slot] <= sq_val;
        end
    end

    for (genvar k = 0; k < N_SYN; k++) begin : g_out
        assign synd_o[k*GF_M +: GF_M] = syn_q[k];

        AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (done_o && (k >= 2 * int'(ctl.t_val))) |-> (syn_q[k] == '0));   // R2
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl.phase == PH_IDLE && !start_i) |=> $stable(synd_o));            // R8
    AST_EVEN_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        (ctl.phase == PH_EVEN && syn_q[src_slot] == '0) |=> (syn_q[$past(even_slot)] == '0)); // R5

endmodule

// File: tb/bchx_syndrome_expand_tb.sv
module bchx_syndrome_expand_tb;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    cap_sel = 3'd0;
    logic [383:0]  rem_words = '0;
    logic [623:0]  synd;
    logic          done;

    int checks = 0;
    int errors = 0;
    logic [12:0] exp_s [1:48];

    always #5 clk = ~clk;

    bchx_syndrome_expand u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cap_sel_i   (cap_sel),
        .rem_words_i (rem_words),
        .synd_o      (synd),
        .done_o      (done)
    );

    // reference field arithmetic: full product, then fold top bits
    function automatic logic [12:0] tb_mul(input logic [12:0] a, input logic [12:0] b);
        logic [24:0] p = '0;
        for (int n = 0; n < 13; n++) if (b[n]) p = p ^ (25'(a) << n);
        for (int d = 24; d >= 13; d--) if (p[d]) p = p ^ (25'h201B << (d - 13));
        return p[12:0];
    endfunction

    function automatic logic [12:0] tb_pow(input int e_in);
        logic [12:0] r = 13'd1;
        logic [12:0] b = 13'd2;
        int e = e_in % 8191;
        while (e > 0) begin
            if (e % 2 == 1) r = tb_mul(r, b);
            b = tb_mul(b, b);
            e = e / 2;
        end
        return r;
    endfunction

    function automatic logic [12:0] get_syn(input int k);
        return synd[(k-1)*13 +: 13];
    endfunction

    function automatic logic [15:0] rem_of(input logic [383:0] w, input int i);
        logic [31:0] word = w[(i/2)*32 +: 32];
        return (i % 2 == 1) ? word[31:16] : word[15:0];
    endfunction

    task automatic compute_expected(input logic [383:0] w, input int t);
        for (int k = 1; k <= 48; k++) exp_s[k] = '0;
        for (int i = 0; i < t; i++) begin
            logic [15:0] r = rem_of(w, i);
            for (int j = 0; j < 13; j++)
                if (r[j]) exp_s[2*i+1] = exp_s[2*i+1] ^ tb_pow((2*i+1) * j);
        end
        for (int j = 1; j <= t; j++) exp_s[2*j] = tb_mul(exp_s[j], exp_s[j]);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic compare_all(input string req);
        for (int k = 1; k <= 48; k++)
            check(get_syn(k) == exp_s[k], req, $sformatf("S%0d", k), get_syn(k), exp_s[k]);
    endtask

    // start a run, measure latency, check the pulse width
    task automatic run(input logic [2:0] code, input logic [383:0] w, input int t_exp);
        int n = 0;
        @(negedge clk);
        cap_sel = code; rem_words = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n == 14 * t_exp, "R6", "latency", n, 14 * t_exp);
        @(negedge clk);
        check(done == 1'b0, "R6", "done width", done, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(synd == '0, "R1", "syndromes after reset", synd[63:0], 0);
        rst = 1'b0;
    endtask

    task automatic t_single_bit();
        logic [383:0] w = '0;
        w[15:0] = 16'h0002;                  // remainder 0, bit 1
        run(3'd0, w, 2);
        check(get_syn(1) == 13'h0002, "R4", "S1 alpha", get_syn(1), 2);
        check(get_syn(2) == 13'h0004, "R5", "S2 square", get_syn(2), 4);
        check(get_syn(3) == 13'h0000, "R4", "S3 zero rem", get_syn(3), 0);
        check(get_syn(4) == 13'h0010, "R5", "S4 square", get_syn(4), 16);
    endtask

    task automatic t_packing();
        logic [383:0] w = '0;
        w[63:32] = 32'h0001_0004;            // rem3 bit0, rem2 bit2
        run(3'd1, w, 4);
        check(get_syn(5) == 13'h0400, "R3", "S5 from lower half", get_syn(5), 13'h400);
        check(get_syn(7) == 13'h0001, "R3", "S7 from upper half", get_syn(7), 1);
        check(get_syn(1) == 13'h0000, "R3", "S1 untouched", get_syn(1), 0);
        compute_expected(w, 4);
        compare_all("R3");
    endtask

    task automatic t_upper_bits();
        logic [383:0] w = {12{32'hE000_E000}};
        run(3'd4, w, 24);
        check(synd == '0, "R4", "bits 13..15 ignored", synd[63:0], 0);
    endtask

    task automatic t_random(input logic [2:0] code, input int t);
        logic [383:0] w;
        for (int r = 0; r < 12; r++) w[r*32 +: 32] = $urandom();
        run(code, w, t);
        compute_expected(w, t);
        compare_all((t == 24) ? "R2" : "R5");
    endtask

    task automatic t_shrink();
        logic [383:0] w;
        for (int r = 0; r < 12; r++) w[r*32 +: 32] = $urandom();
        run(3'd0, w, 2);
        compute_expected(w, 2);
        compare_all("R2");
    endtask

    task automatic t_busy_start();
        logic [383:0] wa;
        logic [383:0] wb;
        int n = 0;
        for (int r = 0; r < 12; r++) begin
            wa[r*32 +: 32] = $urandom();
            wb[r*32 +: 32] = $urandom();
        end
        @(negedge clk);
        cap_sel = 3'd0; rem_words = wa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) begin @(negedge clk); n++; end
        cap_sel = 3'd4; rem_words = wb; start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check(n == 28, "R7", "latency kept", n, 28);
        compute_expected(wa, 2);
        compare_all("R7");
    endtask

    task automatic t_hold();
        logic [623:0] snap = synd;
        repeat (3) @(negedge clk);
        rem_words = ~rem_words; cap_sel = 3'd3;
        repeat (20) @(negedge clk);
        check(synd == snap, "R8", "outputs held", synd[63:0], snap[63:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single_bit();
        t_packing();
        t_upper_bits();
        t_random(3'd2, 8);
        t_random(3'd3, 12);
        t_random(3'd4, 24);
        t_random(3'd7, 24);
        t_shrink();
        t_busy_start();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule